// File: doc/BRIEF.md
# Remote Terminal Command Validator

This block sits behind the word decoder of a dual-redundant serial command/response bus. Each decoded 16-bit command word comes with a one-cycle strobe and an error flag. The block compares the word's address field with a terminal address set by strap pins. It accepts the word when the word is addressed to this terminal or is a broadcast. The strap pins carry their own odd-parity bit. If that parity is wrong, the block refuses every command.

On acceptance the block drives an active-low grant strobe to the subsystem. A fixed number of cycles after the strobe falls, it latches the command's fields: direction, subaddress and word count. It flags mode codes. For a mode code it asks an external lookup table whether that code is illegal on this terminal.

Two cycles after the latch it produces the status word to send back. In the same cycle it pulses status-send when a reply is due, and transfer-start when a data transfer may begin. A broadcast never gets a reply. An illegal command never starts a transfer.

Top module: `rt_cmd_validator`

## Requirements
- R1: The strap address and strap parity bit together must contain an odd number of ones. Otherwise no command is accepted: the grant never falls and the latched fields keep their values. With all six strap inputs at 1 (their unconnected level) the parity check fails.
- R2: A command is accepted when all of the following hold in the same cycle: `cmd_valid` is high, `cmd_err` is low, the block is idle, and the address field (`cmd_word[15:11]`) equals the strap address or equals 31. `ngrant_n` then goes low from the clock edge that samples the command and stays low for GRANT_W cycles.
- R3: A command with a different address, or with `cmd_err` set, produces no grant, no status and no change to the latched fields.
- R4: LATCH_DLY clock edges after the edge where `ngrant_n` fell, the block latches three fields. `cmd_tr` takes `cmd_word[10]`, `cmd_sa` takes `cmd_word[9:5]` and `cmd_wc` takes `cmd_word[4:0]`.
- R5: `cmd_mode` is latched in the same cycle as the fields and is 1 exactly when the subaddress is 0 or 31.
- R6: For a mode code, `lut_rd` pulses in the field-latch cycle with `lut_addr = {broadcast, T/R, word count}`. `cmd_illegal` takes `lut_illegal` one edge later. For any other command `lut_rd` stays low and `cmd_illegal` is 0.
- R7: At LATCH_DLY+2 edges after the grant fell, `status_word` is loaded with these fields:
  - [15:11] the strap address
  - [10] message error
  - [9] instrumentation, always 0
  - [8] `ss_srq`
  - [7:5] reserved, always 0
  - [4] broadcast received
  - [3] `ss_busy`
  - [2] `ss_flag`
  - [1] `ss_dba`
  - [0] `term_flag`

  `sts_par` makes the 17 bits odd.
- R8: For a broadcast, status bit 4 is set and `sts_send` stays low. For any other accepted command, `sts_send` pulses for one cycle together with the status load.
- R9: For an illegal command, status bit 10 is set and `xfer_go` stays low.
- R10: `xfer_go` pulses with the status load only for a legal command that is not a mode code while `ss_busy` is low. When busy, bit 3 reports it and no transfer starts.
- R11: A command strobed while an earlier command is still being processed is ignored and produces no second grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_addr | input | 5 | Strapped terminal address |
| strap_par | input | 1 | Strap parity bit (odd over six bits) |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command word |
| cmd_err | input | 1 | Decoder reports the word as corrupt |
| cmd_word | input | 16 | Decoded command word |
| ss_busy | input | 1 | Subsystem busy |
| ss_flag | input | 1 | Subsystem fault flag |
| ss_srq | input | 1 | Service request |
| ss_dba | input | 1 | Accepts bus control |
| term_flag | input | 1 | Terminal fault flag |
| lut_illegal | input | 1 | Lookup answer for `lut_addr` |
| ngrant_n | output | 1 | Active-low new-command grant |
| cmd_tr | output | 1 | Latched transmit/receive bit |
| cmd_sa | output | 5 | Latched subaddress/mode field |
| cmd_wc | output | 5 | Latched word count/mode code |
| cmd_mode | output | 1 | Latched command is a mode code |
| cmd_illegal | output | 1 | Latched command is illegal |
| lut_rd | output | 1 | Lookup request strobe |
| lut_addr | output | 7 | Lookup address {broadcast, T/R, code} |
| status_word | output | 16 | Status word to return |
| sts_par | output | 1 | Odd parity for status word |
| sts_send | output | 1 | Pulse: send the status word |
| xfer_go | output | 1 | Pulse: data transfer may begin |

## Verification
The assertions rely on three properties of the inputs:
- The straps stay stable while a command is in flight, so the address in the status word matches the straps at send time.
- The lookup table answers from `lut_addr` in the cycle after `lut_rd`.
- The command strobe lasts exactly one cycle.

The stimulus keeps to these rules. It changes the straps only between commands, followed by idle cycles. It models the lookup table as a pure function of `lut_addr`. It raises `cmd_valid` for a single cycle. The only exception is the deliberate mid-command strobe used to show that R11 ignores it.

// File: rtl/rtv_pkg.sv
package rtv_pkg;
  localparam int RTV_AW     = 5;
  localparam int RTV_FW     = 5;
  localparam int RTV_WORD_W = 16;
  localparam int RTV_LUT_W  = RTV_FW + 2;
  localparam logic [RTV_AW-1:0] RTV_BCAST = '1;

  typedef struct packed {
    logic [RTV_AW-1:0] addr;
    logic              tr;
    logic [RTV_FW-1:0] sa;
    logic [RTV_FW-1:0] wc;
  } rtv_cmd_t;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_HOLD = 2'd1,
    SQ_LOOK = 2'd2
  } rtv_seq_e;

  function automatic logic rtv_is_mode(input logic [RTV_FW-1:0] sa);
    return (sa == '0) || (sa == '1);
  endfunction
endpackage

// File: rtl/rtv_addr_match.sv
module rtv_addr_match
  import rtv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [RTV_AW-1:0] strap_addr,
  input  logic              strap_par,
  input  logic [RTV_AW-1:0] cmd_addr,
  output logic              strap_ok,
  output logic [RTV_AW-1:0] own_addr,
  output logic              hit
);
  // Straps are registered once so the match path starts from flops.
  always_ff @(posedge clk) begin
    if (rst) begin
      strap_ok <= 1'b0;
      own_addr <= '0;
    end else begin
      strap_ok <= ^{strap_addr, strap_par};
      own_addr <= strap_addr;
    end
  end

  assign hit = strap_ok && ((cmd_addr == own_addr) || (cmd_addr == RTV_BCAST));
endmodule

// File: rtl/rtv_sequencer.sv
module rtv_sequencer
  import rtv_pkg::*;
#(
  parameter int GRANT_W   = 2,
  parameter int LATCH_DLY = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  rtv_cmd_t             cmd_in,
  input  logic                 lut_illegal,
  output logic                 idle,
  output logic                 ngrant_n,
  output logic                 f_tr,
  output logic [RTV_FW-1:0]    f_sa,
  output logic [RTV_FW-1:0]    f_wc,
  output logic                 f_mode,
  output logic                 f_bcast,
  output logic                 f_illegal,
  output logic                 lut_rd,
  output logic [RTV_LUT_W-1:0] lut_addr,
  output logic                 finish
);
  // GRANT_W must be smaller than LATCH_DLY.
  localparam int CNT_W = $clog2(LATCH_DLY + 1);
  localparam logic [CNT_W-1:0] GRANT_END = CNT_W'(GRANT_W - 1);
  localparam logic [CNT_W-1:0] LATCH_END = CNT_W'(LATCH_DLY - 1);

  rtv_seq_e         state;
  logic [CNT_W-1:0] cnt;
  rtv_cmd_t         pend;
  logic             pend_mode;
  logic             pend_bcast;

  assign idle       = (state == SQ_IDLE);
  assign pend_mode  = rtv_is_mode(pend.sa);
  assign pend_bcast = (pend.addr == RTV_BCAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      cnt       <= '0;
      pend      <= '0;
      ngrant_n  <= 1'b1;
      f_tr      <= 1'b0;
      f_sa      <= '0;
      f_wc      <= '0;
      f_mode    <= 1'b0;
      f_bcast   <= 1'b0;
      f_illegal <= 1'b0;
      lut_rd    <= 1'b0;
      lut_addr  <= '0;
      finish    <= 1'b0;
    end else begin
      lut_rd <= 1'b0;
      finish <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (start) begin
            pend     <= cmd_in;
            ngrant_n <= 1'b0;
            cnt      <= '0;
            state    <= SQ_HOLD;
          end
        end
        SQ_HOLD: begin
          cnt <= cnt + 1'b1;
          if (cnt == GRANT_END) ngrant_n <= 1'b1;
          if (cnt == LATCH_END) begin
            f_tr      <= pend.tr;
            f_sa      <= pend.sa;
            f_wc      <= pend.wc;
            f_mode    <= pend_mode;
            f_bcast   <= pend_bcast;
            f_illegal <= 1'b0;
            lut_rd    <= pend_mode;
            lut_addr  <= {pend_bcast, pend.tr, pend.wc};
            state     <= SQ_LOOK;
          end
        end
        SQ_LOOK: begin
          f_illegal <= f_mode & lut_illegal;
          finish    <= 1'b1;
          state     <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rtv_status.sv
module rtv_status
  import rtv_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  finish,
  input  logic [RTV_AW-1:0]     own_addr,
  input  logic                  f_mode,
  input  logic                  f_bcast,
  input  logic                  f_illegal,
  input  logic                  ss_busy,
  input  logic                  ss_flag,
  input  logic                  ss_srq,
  input  logic                  ss_dba,
  input  logic                  term_flag,
  output logic [RTV_WORD_W-1:0] status_word,
  output logic                  sts_par,
  output logic                  sts_send,
  output logic                  xfer_go
);
  logic [RTV_WORD_W-1:0] nxt;

  // Bit order is fixed by the bus: address first, terminal flag last.
  assign nxt = {own_addr, f_illegal, 1'b0, ss_srq, 3'b000,
                f_bcast, ss_busy, ss_flag, ss_dba, term_flag};

  always_ff @(posedge clk) begin
    if (rst) begin
      status_word <= '0;
      sts_par     <= 1'b1;
      sts_send    <= 1'b0;
      xfer_go     <= 1'b0;
    end else begin
      sts_send <= finish & ~f_bcast;
      xfer_go  <= finish & ~f_illegal & ~f_mode & ~ss_busy;
      if (finish) begin
        status_word <= nxt;
        sts_par     <= ~^nxt;
      end
    end
  end
endmodule

// File: rtl/rt_cmd_validator.sv
module rt_cmd_validator
  import rtv_pkg::*;
#(
  parameter int GRANT_W   = 2,
  parameter int LATCH_DLY = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [RTV_AW-1:0]     strap_addr,
  input  logic                  strap_par,
  input  logic                  cmd_valid,
  input  logic                  cmd_err,
  input  logic [RTV_WORD_W-1:0] cmd_word,
  input  logic                  ss_busy,
  input  logic                  ss_flag,
  input  logic                  ss_srq,
  input  logic                  ss_dba,
  input  logic                  term_flag,
  input  logic                  lut_illegal,
  output logic                  ngrant_n,
  output logic                  cmd_tr,
  output logic [RTV_FW-1:0]     cmd_sa,
  output logic [RTV_FW-1:0]     cmd_wc,
  output logic                  cmd_mode,
  output logic                  cmd_illegal,
  output logic                  lut_rd,
  output logic [RTV_LUT_W-1:0]  lut_addr,
  output logic [RTV_WORD_W-1:0] status_word,
  output logic                  sts_par,
  output logic                  sts_send,
  output logic                  xfer_go
);
  rtv_cmd_t          cmd_s;
  logic              strap_ok;
  logic [RTV_AW-1:0] own_addr;
  logic              hit;
  logic              idle;
  logic              start;
  logic              f_bcast;
  logic              finish;

  assign cmd_s = rtv_cmd_t'(cmd_word);
  assign start = cmd_valid & ~cmd_err & hit & idle;

  rtv_addr_match u_match (
    .clk        (clk),
    .rst        (rst),
    .strap_addr (strap_addr),
    .strap_par  (strap_par),
    .cmd_addr   (cmd_s.addr),
    .strap_ok   (strap_ok),
    .own_addr   (own_addr),
    .hit        (hit)
  );

  rtv_sequencer #(.GRANT_W(GRANT_W), .LATCH_DLY(LATCH_DLY)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .cmd_in      (cmd_s),
    .lut_illegal (lut_illegal),
    .idle        (idle),
    .ngrant_n    (ngrant_n),
    .f_tr        (cmd_tr),
    .f_sa        (cmd_sa),
    .f_wc        (cmd_wc),
    .f_mode      (cmd_mode),
    .f_bcast     (f_bcast),
    .f_illegal   (cmd_illegal),
    .lut_rd      (lut_rd),
    .lut_addr    (lut_addr),
    .finish      (finish)
  );

  rtv_status u_sts (
    .clk         (clk),
    .rst         (rst),
    .finish      (finish),
    .own_addr    (own_addr),
    .f_mode      (cmd_mode),
    .f_bcast     (f_bcast),
    .f_illegal   (cmd_illegal),
    .ss_busy     (ss_busy),
    .ss_flag     (ss_flag),
    .ss_srq      (ss_srq),
    .ss_dba      (ss_dba),
    .term_flag   (term_flag),
    .status_word (status_word),
    .sts_par     (sts_par),
    .sts_send    (sts_send),
    .xfer_go     (xfer_go)
  );
endmodule

// File: rtl/rt_cmd_validator_chk.sv
module rt_cmd_validator_chk (
  input logic        clk,
  input logic        rst,
  input logic        strap_ok,
  input logic [4:0]  strap_addr,
  input logic        cmd_valid,
  input logic        cmd_err,
  input logic        ngrant_n,
  input logic        cmd_mode,
  input logic        cmd_illegal,
  input logic        lut_rd,
  input logic [15:0] status_word,
  input logic        sts_par,
  input logic        sts_send,
  input logic        xfer_go
);
  // R1
  strap_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ngrant_n) |-> $past(strap_ok));

  // R2
  grant_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ngrant_n) |-> $past(cmd_valid && !cmd_err));

  // R6
  lut_mode_chk: assert property (@(posedge clk) disable iff (rst)
    lut_rd |-> cmd_mode);

  // R6
  illegal_mode_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_illegal |-> cmd_mode);

  // R7
  sts_addr_chk: assert property (@(posedge clk) disable iff (rst)
    sts_send |-> (status_word[15:11] == strap_addr) && (^{status_word, sts_par}));

  // R8
  bcast_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    sts_send |-> !status_word[4]);

  // R9
  illegal_noxfer_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_go |-> !cmd_illegal);

  // R10
  xfer_mode_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_go |-> !cmd_mode);
endmodule

bind rt_cmd_validator rt_cmd_validator_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .strap_ok    (strap_ok),
  .strap_addr  (strap_addr),
  .cmd_valid   (cmd_valid),
  .cmd_err     (cmd_err),
  .ngrant_n    (ngrant_n),
  .cmd_mode    (cmd_mode),
  .cmd_illegal (cmd_illegal),
  .lut_rd      (lut_rd),
  .status_word (status_word),
  .sts_par     (sts_par),
  .sts_send    (sts_send),
  .xfer_go     (xfer_go)
);

// File: tb/sim_rt_cmd_validator.sv
module sim_rt_cmd_validator;
  localparam int GW = 2;
  localparam int LD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  strap_addr = 5'd9;
  logic        strap_par = 1'b1;
  logic        cmd_valid = 1'b0, cmd_err = 1'b0;
  logic [15:0] cmd_word = '0;
  logic        ss_busy = 0, ss_flag = 0, ss_srq = 0, ss_dba = 0, term_flag = 0;
  logic        lut_illegal;
  logic        ngrant_n, cmd_tr, cmd_mode, cmd_illegal, lut_rd;
  logic [4:0]  cmd_sa, cmd_wc;
  logic [6:0]  lut_addr;
  logic [15:0] status_word;
  logic        sts_par, sts_send, xfer_go;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  function automatic logic lut_fn(input logic [6:0] a);
    return (a[4:0] >= 5'd21) || (a[6] && a[5]);
  endfunction

  assign lut_illegal = lut_fn(lut_addr);

  rt_cmd_validator #(.GRANT_W(GW), .LATCH_DLY(LD)) u0 (
    .clk(clk), .rst(rst), .strap_addr(strap_addr), .strap_par(strap_par),
    .cmd_valid(cmd_valid), .cmd_err(cmd_err), .cmd_word(cmd_word),
    .ss_busy(ss_busy), .ss_flag(ss_flag), .ss_srq(ss_srq), .ss_dba(ss_dba),
    .term_flag(term_flag), .lut_illegal(lut_illegal), .ngrant_n(ngrant_n),
    .cmd_tr(cmd_tr), .cmd_sa(cmd_sa), .cmd_wc(cmd_wc), .cmd_mode(cmd_mode),
    .cmd_illegal(cmd_illegal), .lut_rd(lut_rd), .lut_addr(lut_addr),
    .status_word(status_word), .sts_par(sts_par), .sts_send(sts_send),
    .xfer_go(xfer_go)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic logic [15:0] exp_status(input logic bc, input logic ill);
    logic [15:0] s;
    s = '0;
    s[15:11] = strap_addr;
    s[10] = ill;
    s[8]  = ss_srq;
    s[4]  = bc;
    s[3]  = ss_busy;
    s[2]  = ss_flag;
    s[1]  = ss_dba;
    s[0]  = term_flag;
    return s;
  endfunction

  task automatic set_strap(input logic [4:0] a, input logic p);
    @(negedge clk);
    strap_addr = a;
    strap_par  = p;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_cmd(input logic [15:0] w, input logic err, input logic intrude);
    logic        strap_good, acc, bc, md, ill, saw_grant, saw_send;
    logic [15:0] sw_exp;
    logic [11:0] old_f;
    strap_good = ^{strap_addr, strap_par};
    bc  = (w[15:11] == 5'd31);
    acc = strap_good && !err && (w[15:11] == strap_addr || bc);
    md  = (w[9:5] == 5'd0) || (w[9:5] == 5'd31);
    ill = md && lut_fn({bc, w[10], w[4:0]});
    sw_exp = exp_status(bc, ill);
    old_f = {cmd_tr, cmd_sa, cmd_wc, cmd_mode};
    @(negedge clk);
    cmd_word = w; cmd_valid = 1'b1; cmd_err = err;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_err = 1'b0;
    if (acc) begin
      chk("R2", "grant low after accept", ngrant_n, 0);
      for (int i = 1; i <= LD + 2; i++) begin
        @(negedge clk);
        if (intrude && i == 2) begin
          cmd_word = {strap_addr, 1'b0, 5'd3, 5'd4}; cmd_valid = 1'b1;
        end else cmd_valid = 1'b0;
        if (i < GW) chk("R2", "grant width", ngrant_n, 0);
        else if (intrude && i <= LD) chk("R11", "no second grant", ngrant_n, 1);
        else if (i == GW) chk("R2", "grant released", ngrant_n, 1);
        if (i == LD) begin
          chk("R4", "latched fields", {cmd_tr, cmd_sa, cmd_wc}, w[10:0]);
          chk("R5", "mode flag", cmd_mode, md);
          chk("R6", "lookup strobe", lut_rd, md);
          if (md) chk("R6", "lookup address", lut_addr, {bc, w[10], w[4:0]});
        end
        if (i == LD + 1) begin
          chk("R6", "illegal flag", cmd_illegal, ill);
          chk("R8", "no early status", sts_send, 0);
        end
        if (i == LD + 2) begin
          chk("R7", "status word", status_word, sw_exp);
          chk("R7", "status parity odd", ^{status_word, sts_par}, 1);
          chk("R8", "status send", sts_send, !bc);
          chk(ill ? "R9" : "R10", "transfer start", xfer_go, !ill && !md && !ss_busy);
        end
      end
      @(negedge clk);
      chk("R8", "status pulse ends", {sts_send, xfer_go}, 0);
    end else begin
      saw_grant = 1'b0; saw_send = 1'b0;
      for (int i = 0; i <= LD + 3; i++) begin
        if (i > 0) @(negedge clk);
        if (!ngrant_n) saw_grant = 1'b1;
        if (sts_send) saw_send = 1'b1;
      end
      chk(strap_good ? "R3" : "R1", "no grant on reject", saw_grant, 0);
      chk(strap_good ? "R3" : "R1", "no status on reject", saw_send, 0);
      chk("R3", "fields unchanged", {cmd_tr, cmd_sa, cmd_wc, cmd_mode}, old_f);
    end
  endtask

  initial begin
    #(10 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    report();
  end

  initial begin
    logic [4:0] a, sa;
    process::self().srandom(32'd1553);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R2", "reset grant idle", ngrant_n, 1);
    chk("R8", "reset no send", {sts_send, xfer_go}, 0);
    chk("R5", "reset mode flag", {cmd_mode, cmd_illegal, lut_rd}, 0);
    set_strap(5'd9, 1'b1);
    // directed corners
    run_cmd({5'd9, 1'b0, 5'd4, 5'd3}, 0, 0);    // own receive, transfer
    run_cmd({5'd9, 1'b1, 5'd0, 5'd2}, 0, 0);    // legal mode code
    run_cmd({5'd9, 1'b0, 5'd31, 5'd25}, 0, 0);  // illegal mode code
    run_cmd({5'd31, 1'b1, 5'd0, 5'd1}, 0, 0);   // broadcast, illegal via table
    run_cmd({5'd31, 1'b0, 5'd7, 5'd5}, 0, 0);   // broadcast receive
    run_cmd({5'd12, 1'b0, 5'd4, 5'd3}, 0, 0);   // other terminal
    run_cmd({5'd9, 1'b0, 5'd4, 5'd3}, 1, 0);    // decoder error
    ss_busy = 1'b1;
    run_cmd({5'd9, 1'b1, 5'd6, 5'd8}, 0, 0);    // busy: no transfer
    ss_busy = 1'b0;
    run_cmd({5'd9, 1'b0, 5'd2, 5'd1}, 0, 1);    // intrusion mid-command
    set_strap(5'd31, 1'b1);                     // unconnected level fails parity
    run_cmd({5'd31, 1'b0, 5'd4, 5'd3}, 0, 0);
    set_strap(5'd9, 1'b0);                      // even parity
    run_cmd({5'd9, 1'b0, 5'd4, 5'd3}, 0, 0);
    set_strap(5'd22, 1'b0);                     // 10110: three ones, odd
    for (int k = 0; k < 60; k++) begin
      {ss_busy, ss_flag, ss_srq, ss_dba, term_flag} = 5'($urandom);
      case ($urandom % 4)
        0: a = 5'd31;
        1: a = 5'($urandom);
        default: a = strap_addr;
      endcase
      case ($urandom % 3)
        0: sa = ($urandom % 2) ? 5'd31 : 5'd0;
        default: sa = 5'($urandom);
      endcase
      run_cmd({a, 1'($urandom), sa, 5'($urandom)}, ($urandom % 8) == 0, 0);
    end
    report();
  end
endmodule